// File: doc/BRIEF.md
# Fuse Word Programming Sequencer

This block burns one word of a one-time-programmable fuse array one bit at a time. A single start request carries a target address and a data word. The block latches the address, the data and the timing word. It then reads the word already stored in the fuse array and removes every bit that is already blown, so no fuse cell is pulsed twice. The remaining bits are then walked from the least significant end. Each cell to be blown receives a program strobe with a quiet interval on both sides of it.

All phase lengths come from a packed timing word and are counted in clock cycles. After the last bit, the block stays busy for a fixed quiet time, which is a parameter, so that the array can settle before another operation. Only after that does it raise a one-cycle completion pulse. The fuse array connects through a read strobe with a data return, a program strobe, a bit index and the latched word address.

Top module: `fuse_prog_seq`

## Requirements
- R1: While reset is high and in the cycle after it, `busy_o`, `done_o`, `fuse_rd_o` and `fuse_prog_o` are all low.
- R2: A start request is accepted only when the block is idle. A start that arrives while the block is busy changes neither the target word nor the operation's length.
- R3: The target address is captured when the start is accepted. `fuse_addr_o` holds that address for the whole operation, whatever `addr_i` does afterwards.
- R4: The timing word has three fields: program strobe length in bits [11:0], quiet length in bits [15:12] and read strobe length in bits [21:16]. Bits [31:22] are ignored. A field of value N gives a phase of N cycles, and a field of zero gives a phase of one cycle. The fields are captured at start.
- R5: The operation begins with `fuse_rd_o` high for the read length. `fuse_rdata_i` is sampled in the last cycle of that strobe.
- R6: A bit that is already 1 in the word read back never receives a program strobe. A 1 in the start data over a 0 in the word read back is blown. A 0 in the start data is never blown.
- R7: Bits are visited in ascending order of `fuse_bit_o`, starting at bit 0. A bit that is not blown takes exactly one cycle.
- R8: Each bit that is blown takes one cycle to visit, then the quiet length, then `fuse_prog_o` high for the program length, then the quiet length again.
- R9: After the last bit, `busy_o` stays high for POST_CYC more cycles. `done_o` is then high for exactly one cycle, with `busy_o` low. The total busy time is therefore read + DATA_W + blown × (2·quiet + program) + POST_CYC.
- R10: `fuse_rd_o` and `fuse_prog_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to program one word |
| addr_i | input | ADDR_W | Target word address |
| data_i | input | DATA_W | Bits to blow (1 = blow) |
| timing_i | input | 32 | Packed phase lengths in cycles |
| busy_o | output | 1 | Operation in progress, including the quiet time at the end |
| done_o | output | 1 | One-cycle completion pulse |
| fuse_addr_o | output | ADDR_W | Latched word address to the fuse array |
| fuse_rd_o | output | 1 | Read strobe to the fuse array |
| fuse_rdata_i | input | DATA_W | Word read from the fuse array |
| fuse_prog_o | output | 1 | Program strobe for one cell |
| fuse_bit_o | output | $clog2(DATA_W) | Index of the cell being visited |

## Verification
The hardest case to reach is a change of address in the middle of an operation, because a correct block shows no sign of it at its ports. The stimulus therefore changes `addr_i` during the read strobe and raises a stray start in the same cycle. It then checks three things: the read and every blow land on the captured word, the busy time matches the formula, and the stray target word is untouched. Masking is reached by programming the same word twice and by presetting words in the bench's fuse model. A preset word that is all ones gives an operation with no strobes at all.

// File: rtl/fuse_seq_pkg.sv
package fuse_seq_pkg;

  // Phase lengths stored as (cycles - 1), so that a field of zero still gives one cycle.
  typedef struct packed {
    logic [11:0] prog;
    logic [3:0]  relax;
    logic [5:0]  rd;
  } fuse_tmg_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_SCAN,
    S_RLX_A,
    S_STRB,
    S_RLX_B,
    S_POST,
    S_DONE
  } seq_state_t;

endpackage

// File: rtl/fuse_tmg_unpack.sv
module fuse_tmg_unpack
  import fuse_seq_pkg::*;
(
  input  logic [31:0] timing_word,
  output fuse_tmg_t   lens
);
  logic [11:0] f_prog;
  logic [3:0]  f_relax;
  logic [5:0]  f_rd;

  assign f_prog  = timing_word[11:0];
  assign f_relax = timing_word[15:12];
  assign f_rd    = timing_word[21:16];

  always_comb begin
    lens.prog  = (f_prog  == '0) ? '0 : f_prog  - 12'd1;
    lens.relax = (f_relax == '0) ? '0 : f_relax - 4'd1;
    lens.rd    = (f_rd    == '0) ? '0 : f_rd    - 6'd1;
  end
endmodule

// File: rtl/fuse_phase_cnt.sv
module fuse_phase_cnt #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/fuse_bit_shift.sv
module fuse_bit_shift #(
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift,
  output logic              lsb_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  logic [DATA_W-1:0] sh_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sh_q  <= load_data;
      idx_q <= '0;
    end else if (shift) begin
      sh_q  <= {1'b0, sh_q[DATA_W-1:1]};
      idx_q <= idx_q + 1'b1;
    end
  end

  assign lsb_o  = sh_q[0];
  assign idx_o  = idx_q;
  assign last_o = (idx_q == IDX_W'(DATA_W-1));
endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
  import fuse_seq_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int POST_CYC = 400
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic [31:0]                timing_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [ADDR_W-1:0]          fuse_addr_o,
  output logic                       fuse_rd_o,
  input  logic [DATA_W-1:0]          fuse_rdata_i,
  output logic                       fuse_prog_o,
  output logic [$clog2(DATA_W)-1:0]  fuse_bit_o
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int PW     = $clog2(POST_CYC + 1);
  localparam int CNT_W  = (PW > 12) ? PW : 12;
  localparam int POST_L = (POST_CYC > 0) ? POST_CYC - 1 : 0;

  seq_state_t        state_q, state_d;
  fuse_tmg_t         tmg_in, tmg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;
  logic              cnt_load, cnt_zero;
  logic [CNT_W-1:0]  cnt_val;
  logic              sh_load, sh_shift, sh_lsb, sh_last;
  logic [IDX_W-1:0]  sh_idx;

  fuse_tmg_unpack u_unpack (
    .timing_word (timing_i),
    .lens        (tmg_in)
  );

  fuse_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (cnt_val),
    .cnt_zero (cnt_zero)
  );

  fuse_bit_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (sh_load),
    .load_data (data_q & ~fuse_rdata_i),
    .shift     (sh_shift),
    .lsb_o     (sh_lsb),
    .idx_o     (sh_idx),
    .last_o    (sh_last)
  );

  assign accept = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_READ;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(tmg_in.rd);
      end
      S_READ: if (cnt_zero) begin
        sh_load = 1'b1;
        state_d = S_SCAN;
      end
      S_SCAN: begin
        if (sh_lsb) begin
          state_d  = S_RLX_A;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(tmg_q.relax);
        end else begin
          sh_shift = 1'b1;
          if (sh_last) begin
            state_d  = S_POST;
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(POST_L);
          end
        end
      end
      S_RLX_A: if (cnt_zero) begin
        state_d  = S_STRB;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(tmg_q.prog);
      end
      S_STRB: if (cnt_zero) begin
        state_d  = S_RLX_B;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(tmg_q.relax);
      end
      S_RLX_B: if (cnt_zero) begin
        sh_shift = 1'b1;
        if (sh_last) begin
          state_d  = S_POST;
          cnt_load = 1'b1;
          cnt_val  = CNT_W'(POST_L);
        end else begin
          state_d  = S_SCAN;
        end
      end
      S_POST: if (cnt_zero) state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      tmg_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= addr_i;
        data_q <= data_i;
        tmg_q  <= tmg_in;
      end
    end
  end

  assign busy_o      = (state_q != S_IDLE) && (state_q != S_DONE);
  assign done_o      = (state_q == S_DONE);
  assign fuse_rd_o   = (state_q == S_READ);
  assign fuse_prog_o = (state_q == S_STRB);
  assign fuse_addr_o = addr_q;
  assign fuse_bit_o  = sh_idx;

  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && !fuse_rd_o && !fuse_prog_o));

  // R10: read and program strobes exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(fuse_rd_o && fuse_prog_o));

  // R8: program strobe only inside an operation
  p_prog_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
    fuse_prog_o |-> busy_o);

  // R3: address held during an operation
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(fuse_addr_o));

  // R7: bit index stable while a strobe is held
  p_bit_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (fuse_prog_o && $past(fuse_prog_o)) |-> $stable(fuse_bit_o));

  // R9: done is a single pulse that follows busy
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R5: the read comes first in every operation
  p_read_first_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> fuse_rd_o);

endmodule

// File: tb/fuse_prog_seq_tb.sv
`timescale 1ns/1ps
module fuse_prog_seq_tb;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 32;
  localparam int POST   = 400;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst, start_i, busy_o, done_o, fuse_rd_o, fuse_prog_o;
  logic [ADDR_W-1:0] addr_i, fuse_addr_o;
  logic [DATA_W-1:0] data_i, fuse_rdata_i;
  logic [31:0]       timing_i;
  logic [4:0]        fuse_bit_o;

  logic [DATA_W-1:0] fmem [0:(1<<ADDR_W)-1];
  assign fuse_rdata_i = fmem[fuse_addr_o];

  fuse_prog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POST_CYC(POST)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .data_i(data_i),
    .timing_i(timing_i), .busy_o(busy_o), .done_o(done_o), .fuse_addr_o(fuse_addr_o),
    .fuse_rd_o(fuse_rd_o), .fuse_rdata_i(fuse_rdata_i), .fuse_prog_o(fuse_prog_o),
    .fuse_bit_o(fuse_bit_o)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] word;
    int                cycles;
    int                nblow;
    int                plen;
    int                rlen;
    logic [ADDR_W-1:0] stray;
    logic [DATA_W-1:0] stray_word;
  } exp_t;
  exp_t q[$];

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor state
  int cyc = 0, rrun = 0, prun = 0, nstrb = 0, last_bit = -1;
  int order_err = 0, dbl = 0, bad_len = 0, bad_raddr = 0;
  bit prev_rd = 0, prev_prog = 0;

  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (busy_o) cyc++;
      if (fuse_rd_o) begin
        rrun++;
        if (q.size() > 0 && fuse_addr_o != q[0].addr) bad_raddr++;
      end else if (prev_rd) begin
        if (q.size() > 0)
          chk(rrun == q[0].rlen, "R5", "read strobe length", rrun, q[0].rlen);
        rrun = 0;
      end
      if (fuse_prog_o) begin
        if (!prev_prog) begin
          if (last_bit >= 0 && int'(fuse_bit_o) <= last_bit) order_err++;
          last_bit = int'(fuse_bit_o);
          if (fmem[fuse_addr_o][fuse_bit_o]) dbl++;
          fmem[fuse_addr_o][fuse_bit_o] = 1'b1;
          nstrb++;
        end
        prun++;
      end else if (prev_prog) begin
        if (q.size() > 0 && prun != q[0].plen) bad_len++;
        prun = 0;
      end
      prev_rd   = fuse_rd_o;
      prev_prog = fuse_prog_o;
      if (done_o) begin
        if (q.size() == 0) begin
          chk(0, "R9", "done without pending operation", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(!busy_o, "R9", "busy low with done", busy_o, 0);
          chk(cyc == e.cycles, "R9", "busy cycles", cyc, e.cycles);
          chk(fmem[e.addr] == e.word, "R6", "final fuse word", fmem[e.addr], e.word);
          chk(nstrb == e.nblow, "R6", "strobe count", nstrb, e.nblow);
          chk(order_err == 0, "R7", "ascending bit order errors", order_err, 0);
          chk(dbl == 0, "R6", "strobe on blown bit", dbl, 0);
          chk(bad_len == 0, "R8", "strobe length errors", bad_len, 0);
          chk(bad_raddr == 0, "R3", "read address errors", bad_raddr, 0);
          chk(fmem[e.stray] == e.stray_word, "R2", "stray word untouched",
              fmem[e.stray], e.stray_word);
        end
        cyc = 0; nstrb = 0; last_bit = -1; order_err = 0; dbl = 0;
        bad_len = 0; bad_raddr = 0;
      end
    end
  end

  function automatic int len1(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  task automatic do_op(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                       input logic [31:0] t, input bit stray_en,
                       input logic [ADDR_W-1:0] stray_a);
    exp_t e;
    int rl, xl, pl, nb;
    rl = len1(int'(t[21:16]));
    xl = len1(int'(t[15:12]));
    pl = len1(int'(t[11:0]));
    nb = $countones(d & ~fmem[a]);
    e.addr = a; e.word = fmem[a] | d; e.nblow = nb; e.plen = pl; e.rlen = rl;
    e.cycles = rl + DATA_W + nb * (2 * xl + pl) + POST;
    e.stray = stray_en ? stray_a : a ^ 7'h40;
    e.stray_word = fmem[e.stray];
    q.push_back(e);
    @(negedge clk);
    addr_i = a; data_i = d; timing_i = t; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (stray_en) begin
      repeat (2) @(negedge clk);
      addr_i = stray_a; data_i = '1; timing_i = 32'h0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    int n;
    n = 0;
    while (n < 200000 && !finished) begin
      @(posedge clk);
      n++;
    end
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", n, 200000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) fmem[i] = '0;
    fmem[9]  = 32'hF0F0_0000;
    fmem[12] = 32'h0000_1234;
    fmem[1]  = 32'hFFFF_FFFF;
    rst = 1'b1; start_i = 1'b0; addr_i = '0; data_i = '0; timing_i = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(!busy_o && !done_o && !fuse_rd_o && !fuse_prog_o, "R1", "outputs in reset",
        {busy_o, done_o, fuse_rd_o, fuse_prog_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1", "outputs after reset", {busy_o, done_o}, 0);

    // R4, R8: field layout with junk in the upper bits
    do_op(7'd5, 32'h0000_00A5, {10'h3FF, 6'd5, 4'd3, 12'd20}, 0, '0);
    // R6: same word again, the blown bits are masked
    do_op(7'd5, 32'h0000_00FF, {10'h000, 6'd5, 4'd3, 12'd20}, 0, '0);
    // R2, R3: address change and stray start while reading
    do_op(7'd9, 32'hFFFF_0001, {10'h000, 6'd6, 4'd2, 12'd9}, 1, 7'd12);
    chk(!busy_o, "R2", "no operation from stray start", busy_o, 0);
    // R4: zero fields give one-cycle phases; R7: bits 0 and 31
    do_op(7'd3, 32'h8000_0001, 32'h0, 0, '0);
    // R7: empty data, only one-cycle visits
    do_op(7'd7, 32'h0, {10'h000, 6'd4, 4'd2, 12'd8}, 0, '0);
    // R6: word already all ones, no strobes
    do_op(7'd1, 32'hFFFF_FFFF, {10'h000, 6'd3, 4'd1, 12'd5}, 0, '0);
    // R10: strobes never overlapped during the run (property covered); check idle end
    chk(!fuse_rd_o && !fuse_prog_o, "R10", "strobes idle at end",
        {fuse_rd_o, fuse_prog_o}, 0);
    chk(q.size() == 0, "R9", "all operations completed", q.size(), 0);

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule